// File: doc/BRIEF.md
# March Algorithm Memory Self-Test Engine

This block is a built-in self-test engine for one single-port synchronous RAM. When a start pulse arrives it runs one of five march algorithms, chosen by a three-bit code, over every cell of the RAM. Every cycle of the run issues exactly one RAM operation. Writes store a solid background of all zeros or all ones. Reads are compared, one cycle later, against the background that the algorithm expects the cell to hold.

An algorithm is a list of march elements. Each element has its own address direction and a list of one to three operations. All operations of an element are applied to one cell before the address moves on. When the run ends, the engine raises `done` and leaves the results on its pins: a fail flag, a saturating count of mismatching reads, and the address, element index and operation index of the first mismatch. The RAM pins are plain control pins with no handshake. The RAM must accept one operation per cycle and return read data exactly one cycle after the read is issued.

Top module: `march_bist`

## Requirements
- R1: After reset, `done`, `busy`, `fail`, `mem_en` and `mem_we` are low and `err_count` is zero.
- R2: `alg_sel` selects the algorithm at start. 0 is MATS, 4n operations. 1 is MATS+, 5n. 2 is MATS++, 6n. 3 is March X, 6n. 4 is March C-, 10n. Here n is `DEPTH`, and exactly that many cycles have `mem_en` high during one run.
- R3: A start pulse with `alg_sel` of 5, 6 or 7 is ignored. No RAM operation is issued, `busy` stays low, and `done` and `err_count` keep their values.
- R4: An element marked ascending, or any order, visits addresses 0 to n-1. An element marked descending visits addresses n-1 down to 0. All operations of an element are issued to one address in consecutive cycles before the address changes. For March C-, the directions of elements 0 to 5 are up, up, up, down, down, up.
- R5: `mem_we` is high only on write operations. A w0 drives `mem_wdata` to all zeros and a w1 drives it to all ones.
- R6: A read whose returned word, sampled on `mem_rdata` one cycle after issue, differs in any bit from the expected background is a mismatch. `err_count` counts mismatches and saturates at its maximum value.
- R7: The first mismatch of a run sets `fail` and latches `fail_addr`, `fail_elem` and `fail_op` (both indices 0-based). Later mismatches leave all three unchanged.
- R8: On a RAM with no faults, a run ends with `fail` low and `err_count` zero.
- R9: `done` rises two cycles after the last operation is issued and stays high until the next accepted start. A start pulse during a run is ignored.
- R10: An accepted start clears `fail`, `err_count` and the first-fail fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled when idle or done |
| alg_sel | input | 3 | Algorithm code (R2) |
| mem_en | output | 1 | RAM operation strobe |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, one cycle after a read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, results valid |
| fail | output | 1 | At least one mismatch in the last run |
| err_count | output | CNT_W | Saturating mismatch count |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 3 | Element index of the first mismatch |
| fail_op | output | 2 | Operation index of the first mismatch |

## Verification
The bench builds the engine with `DEPTH` = 10, `ADDR_W` = 4, `DATA_W` = 4 and `CNT_W` = 3. The depth is not a power of two, so the upper address bound is a real limit rather than the counter's natural wrap. Three bits of count are enough to reach saturation when every cell is stuck at one under March C-, which gives 30 mismatches. The bench's RAM model injects stuck-at faults at chosen addresses. Two faults in a descending element show that the first-fail address follows the march direction.

// File: rtl/march_pkg.sv
package march_pkg;

  localparam int ELEM_W = 3;
  localparam int OP_W   = 2;

  typedef enum logic [2:0] {
    ALG_MATS   = 3'd0,
    ALG_MATSP  = 3'd1,
    ALG_MATSPP = 3'd2,
    ALG_MX     = 3'd3,
    ALG_MCM    = 3'd4
  } alg_e;

  // one operation: write flag and background value
  typedef struct packed {
    logic wr;
    logic val;
  } mop_t;

  // one march element: direction, index of its last op, ops (index 0 first)
  typedef struct packed {
    logic            down;
    logic [OP_W-1:0] last_op;
    mop_t [2:0]      ops;
  } melem_t;

  localparam mop_t OP_R0 = 2'b00;
  localparam mop_t OP_R1 = 2'b01;
  localparam mop_t OP_W0 = 2'b10;
  localparam mop_t OP_W1 = 2'b11;

  function automatic melem_t mk(input logic dn, input logic [OP_W-1:0] lst,
                                input mop_t o0, input mop_t o1, input mop_t o2);
    melem_t e;
    e.down    = dn;
    e.last_op = lst;
    e.ops     = {o2, o1, o0};
    return e;
  endfunction

  function automatic logic [ELEM_W-1:0] last_elem(input alg_e a);
    case (a)
      ALG_MX:  return 3'd3;
      ALG_MCM: return 3'd5;
      default: return 3'd2;
    endcase
  endfunction

  function automatic melem_t elem_of(input alg_e a, input logic [ELEM_W-1:0] i);
    melem_t e;
    e = mk(1'b0, 2'd0, OP_W0, OP_R0, OP_R0);
    if (i != 3'd0) begin
      case (a)
        ALG_MATS: begin
          if (i == 3'd1) e = mk(1'b0, 2'd1, OP_R0, OP_W1, OP_R0);
          else           e = mk(1'b0, 2'd0, OP_R1, OP_R0, OP_R0);
        end
        ALG_MATSP: begin
          if (i == 3'd1) e = mk(1'b0, 2'd1, OP_R0, OP_W1, OP_R0);
          else           e = mk(1'b1, 2'd1, OP_R1, OP_W0, OP_R0);
        end
        ALG_MATSPP: begin
          if (i == 3'd1) e = mk(1'b0, 2'd1, OP_R0, OP_W1, OP_R0);
          else           e = mk(1'b1, 2'd2, OP_R1, OP_W0, OP_R0);
        end
        ALG_MX: begin
          case (i)
            3'd1:    e = mk(1'b0, 2'd1, OP_R0, OP_W1, OP_R0);
            3'd2:    e = mk(1'b1, 2'd1, OP_R1, OP_W0, OP_R0);
            default: e = mk(1'b0, 2'd0, OP_R0, OP_R0, OP_R0);
          endcase
        end
        default: begin
          case (i)
            3'd1:    e = mk(1'b0, 2'd1, OP_R0, OP_W1, OP_R0);
            3'd2:    e = mk(1'b0, 2'd1, OP_R1, OP_W0, OP_R0);
            3'd3:    e = mk(1'b1, 2'd1, OP_R0, OP_W1, OP_R0);
            3'd4:    e = mk(1'b1, 2'd1, OP_R1, OP_W0, OP_R0);
            default: e = mk(1'b0, 2'd0, OP_R0, OP_R0, OP_R0);
          endcase
        end
      endcase
    end
    return e;
  endfunction

endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              down_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q;
  logic              down_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      down_q <= 1'b0;
    end else if (load_i) begin
      down_q <= down_i;
      addr_q <= down_i ? TOP : '0;
    end else if (step_i) begin
      addr_q <= down_q ? addr_q - 1'b1 : addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign last_o = down_q ? (addr_q == '0) : (addr_q == TOP);

  // R4: a descending step lowers the address by one
  a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && down_q && !last_o) |=> addr_q == $past(addr_q) - 1'b1);
  // R4: an ascending step raises the address by one
  a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !down_q && !last_o) |=> addr_q == $past(addr_q) + 1'b1);
endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        alg_sel_i,
  input  logic              addr_last_i,
  output logic              addr_load_o,
  output logic              addr_down_o,
  output logic              addr_step_o,
  output logic              issue_o,
  output mop_t              op_o,
  output logic [ELEM_W-1:0] elem_o,
  output logic [OP_W-1:0]   opidx_o,
  output logic              clear_o,
  output logic              busy_o,
  output logic              done_o
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_DONE} state_e;

  state_e            state_q;
  alg_e              alg_q;
  logic [ELEM_W-1:0] elem_q;
  logic [OP_W-1:0]   op_q;

  melem_t cur, nxt, first;
  logic   go, run, at_last_op, at_last_elem;

  always_comb begin
    cur          = elem_of(alg_q, elem_q);
    nxt          = elem_of(alg_q, elem_q + 1'b1);
    first        = elem_of(alg_e'(alg_sel_i), '0);
    run          = (state_q == S_RUN);
    go           = start_i && (alg_sel_i <= 3'd4) &&
                   (state_q == S_IDLE || state_q == S_DONE);
    at_last_op   = (op_q == cur.last_op);
    at_last_elem = (elem_q == last_elem(alg_q));
  end

  assign addr_load_o = go || (run && at_last_op && addr_last_i && !at_last_elem);
  assign addr_down_o = go ? first.down : nxt.down;
  assign addr_step_o = run && at_last_op && !addr_last_i;
  assign issue_o     = run;
  assign op_o        = cur.ops[op_q];
  assign elem_o      = elem_q;
  assign opidx_o     = op_q;
  assign clear_o     = go;
  assign busy_o      = (state_q == S_RUN) || (state_q == S_DRAIN);
  assign done_o      = (state_q == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      alg_q   <= ALG_MATS;
      elem_q  <= '0;
      op_q    <= '0;
    end else begin
      case (state_q)
        S_RUN: begin
          if (at_last_op) begin
            op_q <= '0;
            if (addr_last_i) begin
              if (at_last_elem) state_q <= S_DRAIN;
              else              elem_q  <= elem_q + 1'b1;
            end
          end else begin
            op_q <= op_q + 1'b1;
          end
        end
        S_DRAIN: state_q <= S_DONE;
        default: begin
          if (go) begin
            alg_q   <= alg_e'(alg_sel_i);
            elem_q  <= '0;
            op_q    <= '0;
            state_q <= S_RUN;
          end
        end
      endcase
    end
  end

  // R2: the element index never passes the algorithm's last element
  a_r2_elem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |-> elem_q <= last_elem(alg_q));
  // R9: a start during a run does not change the algorithm
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RUN && start_i) |=> alg_q == $past(alg_q));
  // R3: an invalid code never begins a run
  a_r3_bad_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && start_i && alg_sel_i > 3'd4) |=> state_q == S_IDLE);
endmodule

// File: rtl/march_read_chk.sv
module march_read_chk
  import march_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              rd_i,
  input  logic              exp_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [CNT_W-1:0]  err_count_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [ELEM_W-1:0] fail_elem_o,
  output logic [OP_W-1:0]   fail_op_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              pend_q, exp_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ELEM_W-1:0] elem_q;
  logic [OP_W-1:0]   op_q;
  logic              mismatch;

  assign mismatch = pend_q && (rdata_i != {DATA_W{exp_q}});

  // stage one: the read's expected value travels with its address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      exp_q  <= 1'b0;
      addr_q <= '0;
      elem_q <= '0;
      op_q   <= '0;
    end else begin
      pend_q <= rd_i && !clear_i;
      if (rd_i) begin
        exp_q  <= exp_i;
        addr_q <= addr_i;
        elem_q <= elem_i;
        op_q   <= op_i;
      end
    end
  end

  // stage two: compare, count, and hold the first failure
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_count_o <= '0;
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
      fail_elem_o <= '0;
      fail_op_o   <= '0;
    end else if (clear_i) begin
      err_count_o <= '0;
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
      fail_elem_o <= '0;
      fail_op_o   <= '0;
    end else if (mismatch) begin
      if (err_count_o != CNT_MAX) err_count_o <= err_count_o + 1'b1;
      if (!fail_o) begin
        fail_o      <= 1'b1;
        fail_addr_o <= addr_q;
        fail_elem_o <= elem_q;
        fail_op_o   <= op_q;
      end
    end
  end

  // R7: the first-fail fields hold while fail stays set
  a_r7_first_fail_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && $past(fail_o)) |-> ($stable(fail_addr_o) && $stable(fail_elem_o) &&
                                   $stable(fail_op_o)));
  // R6: the count never falls except on a clear
  a_r6_count_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clear_i) |-> err_count_o >= $past(err_count_o));
  // R6: a saturated count stays saturated until a clear
  a_r6_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count_o == CNT_MAX && !clear_i) |=> err_count_o == CNT_MAX);
  // R8: the count and the fail flag agree
  a_r8_flag_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o == 1'b0) |-> err_count_o == '0);
endmodule

// File: rtl/march_bist.sv
module march_bist
  import march_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 48,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        alg_sel,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  err_count,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [2:0]        fail_elem,
  output logic [1:0]        fail_op
);
  logic              addr_load, addr_down, addr_step, addr_last;
  logic              issue, clear;
  mop_t              op;
  logic [ELEM_W-1:0] elem;
  logic [OP_W-1:0]   opidx;

  march_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .alg_sel_i   (alg_sel),
    .addr_last_i (addr_last),
    .addr_load_o (addr_load),
    .addr_down_o (addr_down),
    .addr_step_o (addr_step),
    .issue_o     (issue),
    .op_o        (op),
    .elem_o      (elem),
    .opidx_o     (opidx),
    .clear_o     (clear),
    .busy_o      (busy),
    .done_o      (done)
  );

  march_addr_gen #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (addr_load),
    .down_i (addr_down),
    .step_i (addr_step),
    .addr_o (mem_addr),
    .last_o (addr_last)
  );

  march_read_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear),
    .rd_i        (issue && !op.wr),
    .exp_i       (op.val),
    .addr_i      (mem_addr),
    .elem_i      (elem),
    .op_i        (opidx),
    .rdata_i     (mem_rdata),
    .err_count_o (err_count),
    .fail_o      (fail),
    .fail_addr_o (fail_addr),
    .fail_elem_o (fail_elem),
    .fail_op_o   (fail_op)
  );

  assign mem_en    = issue;
  assign mem_we    = issue && op.wr;
  assign mem_wdata = {DATA_W{op.val}};

  // R4: every issued address lies inside the RAM
  a_r4_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> int'(mem_addr) < DEPTH);
  // R9: no RAM traffic while results are presented
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_en && !busy);
endmodule

// File: tb/tb_march_bist.sv
`timescale 1ns/100ps
module tb_march_bist;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 10;
  localparam int DATA_W = 4;
  localparam int CNT_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [2:0]        alg_sel = 3'd0;
  logic              mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic              busy, done, fail;
  logic [CNT_W-1:0]  err_count;
  logic [ADDR_W-1:0] fail_addr;
  logic [2:0]        fail_elem;
  logic [1:0]        fail_op;

  always #2.5 clk = ~clk;

  march_bist #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
    .err_count(err_count), .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_op(fail_op)
  );

  // RAM model with stuck-at faults on bit 0 (kind 1 = stuck at 1, kind 2 = stuck at 0)
  logic [DATA_W-1:0] ram [DEPTH];
  logic [1:0]        f_kind = 2'd0;
  logic              f_all = 1'b0;
  logic [ADDR_W-1:0] f_a0 = '0, f_a1 = '0;

  function automatic logic [DATA_W-1:0] rd_model(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] v;
    logic hit;
    v   = ram[a];
    hit = f_all || a == f_a0 || a == f_a1;
    if (hit && f_kind == 2'd1) v[0] = 1'b1;
    if (hit && f_kind == 2'd2) v[0] = 1'b0;
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata     <= rd_model(mem_addr);
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected op stream for March C-: 1 = write, value, address
  int n_exp;
  bit ew [100];
  bit ev [100];
  int ea [100];

  task automatic build_mcm();
    bit dn [6] = '{0, 0, 0, 1, 1, 0};
    int no [6] = '{1, 2, 2, 2, 2, 1};
    bit w  [6][2] = '{'{1, 0}, '{0, 1}, '{0, 1}, '{0, 1}, '{0, 1}, '{0, 0}};
    bit v  [6][2] = '{'{0, 0}, '{0, 1}, '{1, 0}, '{0, 1}, '{1, 0}, '{0, 0}};
    n_exp = 0;
    for (int e = 0; e < 6; e++)
      for (int k = 0; k < DEPTH; k++)
        for (int o = 0; o < no[e]; o++) begin
          ew[n_exp] = w[e][o];
          ev[n_exp] = v[e][o];
          ea[n_exp] = dn[e] ? DEPTH - 1 - k : k;
          n_exp++;
        end
  endtask

  int ops_seen;
  int seq_bad;
  bit timed_out;

  // start a run; optionally compare each op to the expected stream,
  // optionally pulse a second start at op index poke
  task automatic run(input logic [2:0] alg, input bit cmp_seq, input int poke);
    int t;
    ops_seen = 0; seq_bad = 0; timed_out = 0; t = 0;
    @(negedge clk); start = 1'b1; alg_sel = alg;
    @(negedge clk); start = 1'b0;
    while (!done && t < 2000) begin
      if (mem_en) begin
        if (cmp_seq && ops_seen < n_exp) begin
          if (mem_we != ew[ops_seen] || int'(mem_addr) != ea[ops_seen] ||
              (ew[ops_seen] && mem_wdata != {DATA_W{ev[ops_seen]}})) begin
            if (seq_bad == 0)
              $display("FAIL R4/R5 op %0d: actual we=%0d addr=%0d wd=%0d expected we=%0d addr=%0d val=%0d",
                       ops_seen, mem_we, mem_addr, mem_wdata, ew[ops_seen], ea[ops_seen], ev[ops_seen]);
            seq_bad++;
          end
        end
        ops_seen++;
      end
      if (t == poke) begin start = 1'b1; alg_sel = 3'd4; end
      else           start = 1'b0;
      t++;
      @(negedge clk);
    end
    start = 1'b0;
    if (!done) begin timed_out = 1; chk(0, "R9", "run timeout", t, 0); end
  endtask

  typedef struct packed {
    logic [2:0] alg;
    logic [1:0] kind;
    logic       all;
    logic [3:0] a0;
    logic [3:0] a1;
    logic [7:0] ops;
    logic [3:0] errs;
    logic [3:0] faddr;
    logic [2:0] felem;
    logic [1:0] fop;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{3'd0, 2'd0, 1'b0, 4'd0, 4'd0,  8'd40, 4'd0, 4'd0, 3'd0, 2'd0},
    '{3'd0, 2'd1, 1'b0, 4'd4, 4'd4,  8'd40, 4'd1, 4'd4, 3'd1, 2'd0},
    '{3'd1, 2'd2, 1'b0, 4'd6, 4'd6,  8'd50, 4'd1, 4'd6, 3'd2, 2'd0},
    '{3'd1, 2'd1, 1'b0, 4'd3, 4'd7,  8'd50, 4'd2, 4'd3, 3'd1, 2'd0},
    '{3'd1, 2'd2, 1'b0, 4'd2, 4'd8,  8'd50, 4'd2, 4'd8, 3'd2, 2'd0},
    '{3'd2, 2'd1, 1'b0, 4'd5, 4'd5,  8'd60, 4'd2, 4'd5, 3'd1, 2'd0},
    '{3'd2, 2'd0, 1'b0, 4'd0, 4'd0,  8'd60, 4'd0, 4'd0, 3'd0, 2'd0},
    '{3'd3, 2'd1, 1'b0, 4'd0, 4'd0,  8'd60, 4'd2, 4'd0, 3'd1, 2'd0},
    '{3'd3, 2'd2, 1'b0, 4'd9, 4'd9,  8'd60, 4'd1, 4'd9, 3'd2, 2'd0},
    '{3'd4, 2'd2, 1'b0, 4'd9, 4'd9,  8'd100, 4'd2, 4'd9, 3'd2, 2'd0},
    '{3'd4, 2'd1, 1'b1, 4'd0, 4'd0,  8'd100, 4'd7, 4'd0, 3'd1, 2'd0},
    '{3'd4, 2'd0, 1'b0, 4'd0, 4'd0,  8'd100, 4'd0, 4'd0, 3'd0, 2'd0}
  };

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CNT_W-1:0] keep_cnt;
    build_mcm();
    repeat (3) @(negedge clk);
    // R1: state held in and just after reset
    chk(!done && !busy && !fail && !mem_en && !mem_we && err_count == 0,
        "R1", "reset outputs", {done, busy, fail, mem_en, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !mem_en && err_count == 0, "R1", "after release",
        {done, busy, mem_en}, 0);

    // R2, R6, R7, R8, R10: table of algorithms and injected faults
    foreach (VEC[i]) begin
      f_kind = VEC[i].kind; f_all = VEC[i].all; f_a0 = VEC[i].a0; f_a1 = VEC[i].a1;
      run(VEC[i].alg, 1'b0, -1);
      chk(ops_seen == int'(VEC[i].ops), "R2", $sformatf("vec %0d op count", i),
          ops_seen, VEC[i].ops);
      chk(err_count == VEC[i].errs[CNT_W-1:0], "R6", $sformatf("vec %0d err_count", i),
          err_count, VEC[i].errs);
      chk(fail == (VEC[i].errs != 0), "R8", $sformatf("vec %0d fail flag", i),
          fail, VEC[i].errs != 0);
      if (VEC[i].errs != 0)
        chk(fail_addr == VEC[i].faddr && fail_elem == VEC[i].felem && fail_op == VEC[i].fop,
            "R7", $sformatf("vec %0d first fail addr/elem/op", i),
            fail_addr * 100 + fail_elem * 10 + fail_op,
            VEC[i].faddr * 100 + VEC[i].felem * 10 + VEC[i].fop);
    end
    // R10: vec 11 follows the saturated vec 10 and its clean result was checked above

    // R4, R5: exact op stream of March C-, fault free
    f_kind = 2'd0; f_all = 1'b0;
    run(3'd4, 1'b1, -1);
    chk(seq_bad == 0, "R4", "March C- order and data mismatches", seq_bad, 0);
    chk(ops_seen == n_exp, "R5", "March C- stream length", ops_seen, n_exp);

    // R9: done holds after the run until a new start
    repeat (4) @(negedge clk);
    chk(done && !busy && !mem_en, "R9", "done held", done, 1);

    // R3: invalid algorithm codes are ignored
    f_kind = 2'd1; f_all = 1'b1;
    run(3'd4, 1'b0, -1);
    keep_cnt = err_count;
    for (int c = 5; c < 8; c++) begin
      int en_cnt;
      en_cnt = 0;
      @(negedge clk); start = 1'b1; alg_sel = 3'(c);
      @(negedge clk); start = 1'b0;
      for (int k = 0; k < 4; k++) begin
        if (mem_en || busy) en_cnt++;
        @(negedge clk);
      end
      chk(en_cnt == 0 && done && err_count == keep_cnt, "R3",
          $sformatf("code %0d ignored", c), en_cnt, 0);
    end

    // R9: a start during a MATS+ run does not restart it
    f_kind = 2'd0; f_all = 1'b0;
    run(3'd1, 1'b0, 10);
    chk(ops_seen == 5 * DEPTH, "R9", "busy start ignored op count", ops_seen, 5 * DEPTH);

    // R10: results cleared at the next accepted start
    f_kind = 2'd1; f_all = 1'b1;
    run(3'd0, 1'b0, -1);
    f_kind = 2'd0; f_all = 1'b0;
    @(negedge clk); start = 1'b1; alg_sel = 3'd0;
    @(negedge clk); start = 1'b0;
    chk(!fail && err_count == 0 && fail_addr == 0, "R10", "cleared at start",
        err_count, 0);
    while (!done) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule